// File: doc/BRIEF.md
# CAN Controller Initialization and Configuration Guard

This block owns the handful of control bits that take a CAN protocol controller into and out of its initialization state and that decide when the rest of the controller may be reconfigured. A bus-side write port updates a five-bit control word. Hardware events can also force the controller into initialization: a reset request, an uncorrectable memory error or a bus-off condition. While initialization is active, the transmit line is parked recessive. Once software leaves initialization, the block watches the receive line until the bus has been idle long enough, and only then does it raise its bus-integrated flag.

Configuration access is protected by two bits. The init bit must be set first, and then the config-enable bit is set. Config-enable falls by itself as soon as init is cleared. While config-enable is high, the block holds the Tx and Rx handlers idle. It also keeps the status and pending registers cleared, keeps the timeout counter reloading, and blocks transmit add and cancel requests. The test and monitor bits can only be set under the protected condition, but they may be cleared at any time. The disable-auto-retransmit bit can only move while the protected condition holds.

Top module: `can_init_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` is 5'b00001 (init set, all else clear), `tx_line` is 1 and `bus_on` is 0.
- R2: Init (`ctl_rdata[0]`) becomes 1 on the edge after `hw_init_req`, `mem_ecc_err` or `bus_off` is high, or after a write with `ctl_wdata[0]`=1. A write with `ctl_wdata[0]`=0 and no hardware event clears it.
- R3: `tx_line` is 1 whenever init is 1 or `bus_on` is 0. When `bus_on` is 1, `tx_line` equals `tx_in`.
- R4: With init 0, `bus_on` becomes 1 on the edge of the 11th consecutive `sample_tick` at which `rx_line` is 1. A tick with `rx_line`=0 restarts the count, and cycles without a tick do not count.
- R5: `bus_on` is 0 in the same cycle that init reads 1 again.
- R6: `cfg_wr_en` is 1 exactly when init and config-enable (`ctl_rdata[1]`) are both 1.
- R7: A write sets config-enable from `ctl_wdata[1]` only if init was 1 before that write. Config-enable reads 0 whenever init is 0.
- R8: While config-enable is 1, `stat_clr`, `toc_reload`, `tx_hold` and `rx_hold` are all 1. They are all 0 otherwise.
- R9: `txreq_wr_ok` follows `txreq_wr_in` and `txcan_wr_ok` follows `txcan_wr_in` only while config-enable is 0. Otherwise both outputs are 0.
- R10: Test (`ctl_rdata[2]`) and monitor (`ctl_rdata[3]`) take a written 1 only if init and config-enable were both 1 before the write. A written 0 clears them at any time.
- R11: Disable-auto-retransmit (`ctl_rdata[4]`) takes the written value of `ctl_wdata[4]` only if init and config-enable were both 1 before the write. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Write data: [0] init, [1] config-enable, [2] test, [3] monitor, [4] disable-auto-retransmit |
| ctl_rdata | output | 5 | Current control word, same bit layout |
| hw_init_req | input | 1 | Hardware request to enter initialization |
| mem_ecc_err | input | 1 | Uncorrectable message memory error |
| bus_off | input | 1 | Bus-off entry from error management |
| rx_line | input | 1 | Receive line, 1 = recessive |
| sample_tick | input | 1 | One-cycle strobe at each bit sample point |
| tx_in | input | 1 | Transmit bit from the protocol engine |
| tx_line | output | 1 | Transmit line to the transceiver |
| bus_on | output | 1 | Bus integrated; frame transfer allowed |
| cfg_wr_en | output | 1 | Configuration registers writable |
| stat_clr | output | 1 | Hold status and pending registers cleared |
| toc_reload | output | 1 | Reload timeout counter from its period |
| tx_hold | output | 1 | Hold Tx handler idle |
| rx_hold | output | 1 | Hold Rx handler idle |
| txreq_wr_in | input | 1 | Transmit add-request write strobe |
| txcan_wr_in | input | 1 | Transmit cancel-request write strobe |
| txreq_wr_ok | output | 1 | Gated add-request write |
| txcan_wr_ok | output | 1 | Gated cancel-request write |

## Verification
The hardest state to reach is an interrupted bus integration. Ten recessive samples are followed by a dominant one and then by idle cycles with no sample strobe, and the flag must still stay low until eleven fresh recessive samples arrive. The stimulus drives `sample_tick` and `rx_line` bit by bit from a task, inserts strobe-free gaps, and then triggers bus-off to confirm the flag falls in the same cycle. The protected-write rules are reached by a table of write sequences in which each entry depends on the control word left by the previous one.

// File: rtl/can_init_pkg.sv
package can_init_pkg;

    localparam int CTL_W     = 5;
    localparam int IDLE_BITS = 11;

    typedef struct packed {
        logic dar;
        logic mon;
        logic test;
        logic cce;
        logic init;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{dar: 1'b0, mon: 1'b0, test: 1'b0, cce: 1'b0, init: 1'b1};

    // A bit that may only be set under protection but cleared at any time
    function automatic logic guarded_set(input logic cur, input logic wbit, input logic prot);
        return wbit ? (cur | prot) : 1'b0;
    endfunction

endpackage

// File: rtl/can_init_regs.sv
module can_init_regs
    import can_init_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  ctl_t wdata,
    input  logic force_init,
    output ctl_t q
);
    ctl_t nxt;
    logic prot;

    always_comb begin
        prot = q.init & q.cce;
        nxt  = q;
        if (wr) begin
            nxt.init = wdata.init;
            nxt.cce  = q.init & wdata.cce;
            nxt.test = guarded_set(q.test, wdata.test, prot);
            nxt.mon  = guarded_set(q.mon, wdata.mon, prot);
            nxt.dar  = prot ? wdata.dar : q.dar;
        end
        if (force_init) begin
            nxt.init = 1'b1;
        end
        if (!nxt.init) begin
            nxt.cce = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTL_RESET;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/can_idle_sync.sv
module can_idle_sync #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tick,
    input  logic rx,
    output logic integrated
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_n;
    logic          integ_q;

    always_comb begin
        run_n = run_q;
        if (tick && !integ_q) begin
            if (!rx) begin
                run_n = '0;
            end else if (run_q != LIMIT) begin
                run_n = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            run_q   <= '0;
            integ_q <= 1'b0;
        end else begin
            run_q <= run_n;
            if (run_n == LIMIT) begin
                integ_q <= 1'b1;
            end
        end
    end

    assign integrated = integ_q & ~hold;
endmodule

// File: rtl/can_init_gate.sv
module can_init_gate (
    input  logic init,
    input  logic cce,
    input  logic integrated,
    input  logic tx_in,
    input  logic txreq_in,
    input  logic txcan_in,
    output logic tx_line,
    output logic bus_on,
    output logic cfg_wr_en,
    output logic stat_clr,
    output logic toc_reload,
    output logic tx_hold,
    output logic rx_hold,
    output logic txreq_ok,
    output logic txcan_ok
);
    always_comb begin
        bus_on     = integrated & ~init;
        tx_line    = bus_on ? tx_in : 1'b1;
        cfg_wr_en  = init & cce;
        stat_clr   = cce;
        toc_reload = cce;
        tx_hold    = cce;
        rx_hold    = cce;
        txreq_ok   = txreq_in & ~cce;
        txcan_ok   = txcan_in & ~cce;
    end
endmodule

// File: rtl/can_init_ctrl.sv
module can_init_ctrl
    import can_init_pkg::*;
#(
    parameter int IDLE_RUN = IDLE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             hw_init_req,
    input  logic             mem_ecc_err,
    input  logic             bus_off,
    input  logic             rx_line,
    input  logic             sample_tick,
    input  logic             tx_in,
    output logic             tx_line,
    output logic             bus_on,
    output logic             cfg_wr_en,
    output logic             stat_clr,
    output logic             toc_reload,
    output logic             tx_hold,
    output logic             rx_hold,
    input  logic             txreq_wr_in,
    input  logic             txcan_wr_in,
    output logic             txreq_wr_ok,
    output logic             txcan_wr_ok
);
    ctl_t ctl_q;
    logic integrated;
    logic force_init;

    assign force_init = hw_init_req | mem_ecc_err | bus_off;

    can_init_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (ctl_wr),
        .wdata      (ctl_t'(ctl_wdata)),
        .force_init (force_init),
        .q          (ctl_q)
    );

    can_idle_sync #(.RUN_LEN(IDLE_RUN)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .hold       (ctl_q.init),
        .tick       (sample_tick),
        .rx         (rx_line),
        .integrated (integrated)
    );

    can_init_gate u_gate (
        .init       (ctl_q.init),
        .cce        (ctl_q.cce),
        .integrated (integrated),
        .tx_in      (tx_in),
        .txreq_in   (txreq_wr_in),
        .txcan_in   (txcan_wr_in),
        .tx_line    (tx_line),
        .bus_on     (bus_on),
        .cfg_wr_en  (cfg_wr_en),
        .stat_clr   (stat_clr),
        .toc_reload (toc_reload),
        .tx_hold    (tx_hold),
        .rx_hold    (rx_hold),
        .txreq_ok   (txreq_wr_ok),
        .txcan_ok   (txcan_wr_ok)
    );

    assign ctl_rdata = ctl_q;
endmodule

// File: rtl/can_init_chk.sv
module can_init_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] ctl_rdata,
    input logic       hw_init_req,
    input logic       mem_ecc_err,
    input logic       bus_off,
    input logic       tx_line,
    input logic       bus_on,
    input logic       cfg_wr_en,
    input logic       stat_clr,
    input logic       toc_reload,
    input logic       tx_hold,
    input logic       rx_hold,
    input logic       txreq_wr_ok,
    input logic       txcan_wr_ok
);
    p_force_init_r2: assert property (@(posedge clk) disable iff (rst)
        (hw_init_req || mem_ecc_err || bus_off) |=> ctl_rdata[0]);

    p_tx_recessive_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] |-> tx_line);

    p_bus_on_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] |-> !bus_on);

    p_cfg_gate_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> (ctl_rdata[0] && ctl_rdata[1]));

    p_cce_needs_init_r7: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[1] |-> ctl_rdata[0]);

    p_holds_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[1] |-> (stat_clr && toc_reload && tx_hold && rx_hold));

    p_txreq_block_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[1] |-> (!txreq_wr_ok && !txcan_wr_ok));

    p_test_set_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rdata[2]) |-> $past(ctl_rdata[0] && ctl_rdata[1]));

    p_mon_set_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rdata[3]) |-> $past(ctl_rdata[0] && ctl_rdata[1]));

    p_dar_move_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_rdata[4]) |-> $past(ctl_rdata[0] && ctl_rdata[1]));
endmodule

bind can_init_ctrl can_init_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_rdata   (ctl_rdata),
    .hw_init_req (hw_init_req),
    .mem_ecc_err (mem_ecc_err),
    .bus_off     (bus_off),
    .tx_line     (tx_line),
    .bus_on      (bus_on),
    .cfg_wr_en   (cfg_wr_en),
    .stat_clr    (stat_clr),
    .toc_reload  (toc_reload),
    .tx_hold     (tx_hold),
    .rx_hold     (rx_hold),
    .txreq_wr_ok (txreq_wr_ok),
    .txcan_wr_ok (txcan_wr_ok)
);

// File: tb/sim_can_init_ctrl.sv
`timescale 1ns/1ps
module sim_can_init_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic       hw_init_req = 1'b0, mem_ecc_err = 1'b0, bus_off = 1'b0;
    logic       rx_line = 1'b1, sample_tick = 1'b0, tx_in = 1'b1;
    logic       tx_line, bus_on, cfg_wr_en, stat_clr, toc_reload, tx_hold, rx_hold;
    logic       txreq_wr_in = 1'b0, txcan_wr_in = 1'b0, txreq_wr_ok, txcan_wr_ok;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_init_ctrl u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .hw_init_req(hw_init_req), .mem_ecc_err(mem_ecc_err), .bus_off(bus_off),
        .rx_line(rx_line), .sample_tick(sample_tick), .tx_in(tx_in), .tx_line(tx_line),
        .bus_on(bus_on), .cfg_wr_en(cfg_wr_en), .stat_clr(stat_clr), .toc_reload(toc_reload),
        .tx_hold(tx_hold), .rx_hold(rx_hold), .txreq_wr_in(txreq_wr_in),
        .txcan_wr_in(txcan_wr_in), .txreq_wr_ok(txreq_wr_ok), .txcan_wr_ok(txcan_wr_ok)
    );

    // {write data, expected control word after the write}
    localparam logic [9:0] VEC [0:11] = '{
        {5'b00011, 5'b00011},
        {5'b11111, 5'b11111},
        {5'b00001, 5'b00001},
        {5'b11101, 5'b00001},
        {5'b00011, 5'b00011},
        {5'b01101, 5'b01101},
        {5'b10000, 5'b00000},
        {5'b00011, 5'b00001},
        {5'b10011, 5'b00011},
        {5'b10011, 5'b10011},
        {5'b10000, 5'b10000},
        {5'b00001, 5'b10001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(posedge clk);
        #1;
        ctl_wr = 1'b0;
    endtask

    task automatic tick(input logic r);
        @(negedge clk);
        sample_tick = 1'b1;
        rx_line = r;
        @(posedge clk);
        #1;
        sample_tick = 1'b0;
        rx_line = 1'b1;
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: hw_init_req = 1'b1;
            1: mem_ecc_err = 1'b1;
            default: bus_off = 1'b1;
        endcase
        @(posedge clk);
        #1;
        hw_init_req = 1'b0;
        mem_ecc_err = 1'b0;
        bus_off = 1'b0;
    endtask

    task automatic integrate();
        for (int i = 0; i < 11; i++) tick(1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rdata", ctl_rdata, 5'b00001);
        chk("R1 tx_line", tx_line, 1);
        chk("R1 bus_on", bus_on, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][9:5]);
            chk("R7/R10/R11 word", ctl_rdata, VEC[i][4:0]);
            chk("R6 cfg_wr_en", cfg_wr_en, VEC[i][0] & VEC[i][1]);
            chk("R8 holds", {stat_clr, toc_reload, tx_hold, rx_hold}, {4{VEC[i][1]}});
        end

        // R9 request gating
        wr(5'b00011);
        @(negedge clk);
        txreq_wr_in = 1'b1;
        txcan_wr_in = 1'b1;
        #1;
        chk("R9 blocked", {txreq_wr_ok, txcan_wr_ok}, 2'b00);
        txreq_wr_in = 1'b0;
        txcan_wr_in = 1'b0;
        wr(5'b00001);
        @(negedge clk);
        txreq_wr_in = 1'b1;
        #1;
        chk("R9 pass req", {txreq_wr_ok, txcan_wr_ok}, 2'b10);
        txreq_wr_in = 1'b0;
        txcan_wr_in = 1'b1;
        #1;
        chk("R9 pass can", {txreq_wr_ok, txcan_wr_ok}, 2'b01);
        txcan_wr_in = 1'b0;

        // R2 clear init, R3/R4 integration
        wr(5'b00000);
        chk("R2 clear init", ctl_rdata[0], 0);
        tx_in = 1'b0;
        #1;
        chk("R3 recessive before integration", tx_line, 1);
        for (int i = 0; i < 10; i++) tick(1'b1);
        chk("R4 ten recessive", bus_on, 0);
        tick(1'b0);
        for (int i = 0; i < 10; i++) tick(1'b1);
        chk("R4 restart after dominant", bus_on, 0);
        repeat (5) @(posedge clk);
        #1;
        chk("R4 no count without tick", bus_on, 0);
        tick(1'b1);
        chk("R4 eleventh recessive", bus_on, 1);
        @(negedge clk);
        tx_in = 1'b0;
        #1;
        chk("R3 follows tx_in low", tx_line, 0);
        tx_in = 1'b1;
        #1;
        chk("R3 follows tx_in high", tx_line, 1);
        tx_in = 1'b0;

        // R2/R5 forced re-entry
        pulse_evt(2);
        chk("R2 bus_off sets init", ctl_rdata[0], 1);
        chk("R5 bus_on drop", bus_on, 0);
        chk("R3 recessive in init", tx_line, 1);
        wr(5'b00000);
        integrate();
        chk("R4 reintegrate", bus_on, 1);
        pulse_evt(0);
        chk("R2 hw request", ctl_rdata[0], 1);
        chk("R5 drop on hw request", bus_on, 0);
        wr(5'b00000);
        pulse_evt(1);
        chk("R2 memory error", ctl_rdata[0], 1);
        tx_in = 1'b1;

        // R1 reset mid-run
        wr(5'b01111);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset again", ctl_rdata, 5'b00001);
        @(negedge clk);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule